// File: doc/BRIEF.md
# Status-First PSK Reply Transmitter

This block sends a reply from a card to a reader by switching an antenna load on and off. The load follows a subcarrier at half the frequency of the carrier the card receives. The phase of that subcarrier carries the data. A flip-flop toggles on every rising edge of the extracted carrier to make the subcarrier. A data value of 1 turns the subcarrier phase over by half a cycle at the start of its bit. A value of 0 leaves the phase as it is.

Each reply begins with a raw status byte. A status of zero means the card is healthy. In that case, data bytes follow the status, taken from a valid/ready stream until the byte marked last, and each byte goes out in start-stop framing with a parity bit. A non-zero status means at least one abnormal condition is set. That status is sent alone, and the data stream is never read. A start strobe begins a reply, and `busy_o` stays high until the final bit has ended.

Top module: `psk_reply_tx`

## Requirements
- R1: The subcarrier toggles once at every rising edge of `carrier_in` and at no other time, so its frequency is half the carrier frequency.
- R2: Every transmitted bit lasts exactly 16 rising edges of `carrier_in`, which is 8 subcarrier periods. Bits change only at a carrier rising edge. The first bit begins at the first carrier rise after the start is accepted.
- R3: While a bit is being sent, `load_mod_o` equals the subcarrier XOR a phase flag. The phase flag is cleared when a start is accepted and inverts at the beginning of each bit whose value is 1. `load_mod_o` is 0 when the block is idle, and also after start and before the first bit.
- R4: A reply always opens with the 8 bits of `status_i`, captured at the start, least significant bit first, with no start, parity or stop bit.
- R5: If the status is 00h, data bytes follow the status. Each byte is framed as a start bit of 0, then 8 data bits LSB first, then an even-parity bit equal to the XOR of the 8 data bits, then one stop bit of 1. Bytes are sent in stream order, up to and including the byte accepted with `data_last_i` high.
- R6: If the status is non-zero, the reply ends after the 8 status bits. `data_ready_o` is never asserted during that reply, and no byte is consumed.
- R7: `busy_o` rises in the cycle after an accepted start. It falls in the cycle of the carrier rise that ends the final bit. `load_mod_o` is 0 from that point on.
- R8: A start strobe while `busy_o` is high is ignored, and the reply in progress is sent unchanged.
- R9: After reset, `busy_o`, `load_mod_o` and `data_ready_o` are 0.
- R10: A byte is taken on each cycle where `data_valid_i` and `data_ready_o` are both high. `data_ready_o` is high only during a zero-status reply, only while no byte is held, and only until the last byte has been taken. Ready rises in the cycle after the start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the carrier |
| rst_n | input | 1 | Active-low synchronous reset |
| carrier_in | input | 1 | Extracted receive carrier, synchronous to clk |
| start_i | input | 1 | Start strobe for a reply |
| status_i | input | 8 | Status byte, captured at start |
| data_i | input | 8 | Data byte of the stream |
| data_last_i | input | 1 | Marks the final data byte |
| data_valid_i | input | 1 | Data byte is valid |
| data_ready_o | output | 1 | Block accepts a data byte |
| busy_o | output | 1 | Reply in progress |
| load_mod_o | output | 1 | Load modulation enable |

## Verification
Directed replies cover a status of 00h with data bytes of 00h and FFh. The all-zero byte keeps the phase steady through every data bit. The all-ones byte flips the phase at every bit, so together they separate phase-hold from phase-flip and expose the parity and stop bits. Single-bit status values of 01h and 80h check the bit order and the suppression of data. Random replies use random status and a random number of bytes (1 to 4), which covers back-to-back frames and the end on the last byte. One reply carries a second start strobe in the middle to show it is ignored. The bench samples the load output after every carrier rise and compares it with a subcarrier and phase model of its own.

// File: rtl/psk_reply_tx.sv
module psk_reply_tx #(
  parameter int BYTE_W        = 8,
  parameter int EDGES_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              carrier_in,
  input  logic              start_i,
  input  logic [BYTE_W-1:0] status_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              data_last_i,
  input  logic              data_valid_i,
  output logic              data_ready_o,
  output logic              busy_o,
  output logic              load_mod_o
);
  localparam int FR_W   = BYTE_W + 3;
  localparam int CNT_W  = $clog2(EDGES_PER_BIT);
  localparam int LEFT_W = $clog2(FR_W + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(EDGES_PER_BIT - 1);

  logic              car_q, sub_q, busy_q, run_q, phase_q, data_q, have_q, got_last_q;
  logic [CNT_W-1:0]  ecnt_q;
  logic [FR_W-1:0]   sh_q;
  logic [LEFT_W-1:0] left_q;
  logic [BYTE_W-1:0] stat_q, buf_q;

  wire rise    = carrier_in & ~car_q;
  wire take    = start_i & ~busy_q;
  wire stat_ok = (stat_q == '0);
  assign data_ready_o = busy_q & stat_ok & ~have_q & ~got_last_q;
  wire hs      = data_valid_i & data_ready_o;
  wire bound   = rise & busy_q & (~run_q | (ecnt_q == CNT_LAST));
  wire more    = (left_q != '0);
  wire finish  = ~more & (data_q ? (got_last_q & ~have_q) : ~stat_ok);
  wire nbit    = more ? sh_q[0] : ~have_q;
  wire [FR_W-1:0] frame = {1'b1, ^buf_q, buf_q, 1'b0};

  assign busy_o     = busy_q;
  assign load_mod_o = run_q & (sub_q ^ phase_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      car_q <= 1'b0; sub_q <= 1'b0; busy_q <= 1'b0; run_q <= 1'b0;
      phase_q <= 1'b0; data_q <= 1'b0; have_q <= 1'b0; got_last_q <= 1'b0;
      ecnt_q <= '0; sh_q <= '0; left_q <= '0; stat_q <= '0; buf_q <= '0;
    end else begin
      car_q <= carrier_in;
      if (rise) sub_q <= ~sub_q;
      if (hs) begin
        buf_q      <= data_i;
        have_q     <= 1'b1;
        got_last_q <= data_last_i;
      end
      if (take) begin
        busy_q <= 1'b1; run_q <= 1'b0; phase_q <= 1'b0; ecnt_q <= '0;
        sh_q <= FR_W'(status_i); left_q <= LEFT_W'(BYTE_W);
        data_q <= 1'b0; stat_q <= status_i; got_last_q <= 1'b0; have_q <= 1'b0;
      end else if (busy_q && rise) begin
        if (bound) begin
          if (finish) begin
            busy_q <= 1'b0;
            run_q  <= 1'b0;
          end else begin
            run_q   <= 1'b1;
            ecnt_q  <= '0;
            phase_q <= phase_q ^ nbit;
            if (more) begin
              sh_q   <= sh_q >> 1;
              left_q <= left_q - 1'b1;
            end else if (have_q) begin
              sh_q   <= frame >> 1;
              left_q <= LEFT_W'(FR_W - 1);
              have_q <= 1'b0;
              data_q <= 1'b1;
            end else begin
              data_q <= 1'b1;
            end
          end
        end else begin
          ecnt_q <= ecnt_q + 1'b1;
        end
      end
    end
  end

  AST_SUB_ONLY_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !rise |=> $stable(sub_q)); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !load_mod_o); // R3
  AST_PHASE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (!bound && !take) |=> $stable(phase_q)); // R2
  AST_NO_DATA_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !stat_ok) |=> !have_q); // R6
  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_q) |=> busy_q); // R7
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start_i) |=> $stable(stat_q)); // R8
endmodule

// File: tb/sim_psk_reply_tx.sv
module sim_psk_reply_tx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic carrier_in = 1'b0, start_i = 1'b0, data_last_i = 1'b0, data_valid_i = 1'b0;
  logic [7:0] status_i = 8'h00, data_i = 8'h00;
  logic data_ready_o, busy_o, load_mod_o;

  int checks = 0, errors = 0;
  int rises = 0, idx = 0, nbytes = 0;
  logic hs_q = 1'b0, rdy_seen = 1'b0;
  logic [7:0] q [0:3];
  logic bits [0:63];
  int nb;

  always #2 clk = ~clk;

  psk_reply_tx u0 (.clk(clk), .rst_n(rst_n), .carrier_in(carrier_in), .start_i(start_i),
    .status_i(status_i), .data_i(data_i), .data_last_i(data_last_i),
    .data_valid_i(data_valid_i), .data_ready_o(data_ready_o), .busy_o(busy_o),
    .load_mod_o(load_mod_o));

  always @(posedge clk) hs_q <= data_valid_i & data_ready_o;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive_data();
    data_valid_i = (idx < nbytes);
    data_i       = (idx < nbytes) ? q[idx] : 8'h00;
    data_last_i  = (idx == nbytes - 1);
  endtask

  task automatic tick();
    @(negedge clk);
    if (hs_q) idx++;
    drive_data();
    if (data_ready_o) rdy_seen = 1'b1;
  endtask

  function automatic int build(input logic [7:0] s, input int n);
    int k = 0;
    for (int i = 0; i < 8; i++) begin bits[k] = s[i]; k++; end
    if (s == 8'h00)
      for (int b = 0; b < n; b++) begin
        bits[k] = 1'b0; k++;
        for (int i = 0; i < 8; i++) begin bits[k] = q[b][i]; k++; end
        bits[k] = ^q[b]; k++;
        bits[k] = 1'b1; k++;
      end
    return k;
  endfunction

  task automatic reply(input logic [7:0] s, input int n, input bit inject);
    logic ph = 1'b0;
    nbytes = n; idx = 0; rdy_seen = 1'b0;
    nb = build(s, n);
    drive_data();
    status_i = s; start_i = 1'b1;
    tick();
    start_i = 1'b0;
    check("R7 busy after start", busy_o, 1);
    check("R3 quiet before first bit", load_mod_o, 0);
    check("R10 ready after start", data_ready_o, (s == 8'h00) ? 1 : 0);
    for (int r = 1; r <= 16 * nb + 1; r++) begin
      tick(); tick(); tick();
      carrier_in = 1'b1;
      tick();
      rises++;
      if (r <= 16 * nb) begin
        if ((r - 1) % 16 == 0) ph = ph ^ bits[(r - 1) / 16];
        check("R3/R4/R5 load output", load_mod_o, (rises % 2) ^ ph);
        if ((r - 1) % 16 == 0) check("R7 busy during reply", busy_o, 1);
      end else begin
        check("R7 busy falls at end", busy_o, 0);
        check("R7 load off at end", load_mod_o, 0);
      end
      if (inject && r == 20) begin start_i = 1'b1; status_i = ~s; end
      tick();
      start_i = 1'b0;
      tick(); tick();
      carrier_in = 1'b0;
    end
    tick();
    if (s == 8'h00) begin
      check("R5/R10 bytes consumed", idx, n);
    end else begin
      check("R6 no byte consumed", idx, 0);
      check("R6 ready never high", rdy_seen, 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    tick();
    check("R9 busy after reset", busy_o, 0);
    check("R9 load after reset", load_mod_o, 0);
    check("R9 ready after reset", data_ready_o, 0);
    // R1 R2 subcarrier and bit length checked through every sample
    q[0] = 8'h00; reply(8'h00, 1, 1'b0);
    q[0] = 8'hFF; q[1] = 8'h5A; reply(8'h00, 2, 1'b0);
    q[0] = 8'h3C; reply(8'h01, 1, 1'b0);          // R6
    q[0] = 8'hA5; reply(8'h80, 1, 1'b0);          // R4 R6
    q[0] = 8'h81; q[1] = 8'h7E; reply(8'h00, 2, 1'b1); // R8
    q[0] = 8'h11; reply(8'h24, 1, 1'b1);          // R8
    for (int t = 0; t < 6; t++) begin
      int n = 1 + int'($urandom % 4);
      logic [7:0] s = ($urandom % 2) ? 8'h00 : 8'($urandom);
      for (int b = 0; b < 4; b++) q[b] = 8'($urandom);
      reply(s, n, 1'b0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule